// File: doc/BRIEF.md
# Low-Speed USB Receive Deserializer

This block turns the differential D+/D- pair of a low-speed USB link into a stream of bytes. It runs from a clock at eight times the line bit rate, so each bit lasts eight cycles. Both line inputs pass through a two-flop synchronizer. The block then looks for the sync field and sets its sampling phase from one J-to-K transition. From then on it samples each bit near its centre, decodes the NRZI levels, drops stuffed bits and packs the data bits into bytes, least significant bit first.

A consumer takes each byte from `rx_byte` while `rx_valid` pulses. Three outcomes end a packet: a clean end marked by `pkt_end`, which reports the byte count on `pkt_len`; an overrun of the byte budget marked by `overflow`; a failed sync search marked by `sync_err`. After any of them the block waits for the line to return to J before it looks for the next packet. CRC checking and PID handling belong to later stages.

Top module: `usb_ls_rx_deser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rx_valid`, `pkt_end`, `overflow` and `sync_err` are low and `pkt_len` is zero.
- R2: Lines are J when dm=1 and dp=0, K when dp=1 and dm=0, and SE0 when both are 0. From idle J, a packet starts with the sync levels K J K J K J K K. The block locks on a J-to-K edge and checks the bit one period later. If that bit is J, it hunts for the next K edge. If that bit is K, sync has ended and data reception begins.
- R3: A data bit is 1 when the sampled level equals the level sampled in the previous bit period, and 0 when it differs. Bits fill each byte LSB first. After every eighth data bit, `rx_byte` holds the byte and `rx_valid` is high for one cycle.
- R4: After six consecutive decoded 1 bits, the next bit is a stuffed bit. It is discarded and the one-count restarts from zero. The final 1 of the sync field counts as the first one.
- R5: SE0 sampled in the second bit slot of a byte ends the packet. `pkt_end` pulses for one cycle, and `pkt_len` gives the number of bytes emitted in this packet. A partial byte is discarded. SE0 in the first slot is decoded as an ordinary bit and never produces a byte on its own.
- R6: At most BUF_BYTES (default 8) bytes are emitted per packet. When one more byte completes, `overflow` pulses instead of `rx_valid`, that byte is not emitted, no `pkt_end` follows, and the block returns to idle.
- R7: A search window of SYNC_WIN (default 10) cycles applies twice. After the first K, if no J arrives within the window, `sync_err` pulses. After that J, if no K edge arrives within the window, `sync_err` pulses. In both cases no data is emitted.
- R8: While `enable` is low, the block stays idle, line activity has no effect, and none of the strobes rises.
- R9: In any cycle at most one of `rx_valid`, `pkt_end`, `overflow` and `sync_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low forces idle |
| dp_in | input | 1 | D+ line, asynchronous |
| dm_in | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Received byte, valid with `rx_valid` |
| rx_valid | output | 1 | One-cycle byte strobe |
| pkt_end | output | 1 | One-cycle end-of-packet strobe |
| pkt_len | output | LW | Bytes received in the packet, valid with `pkt_end` |
| overflow | output | 1 | One-cycle strobe on byte budget overrun |
| sync_err | output | 1 | One-cycle strobe on failed sync search |

## Verification
The assertions assume that `enable` changes only between packets or while the line idles. They also assume that bytes arrive at least one bit period apart, which holds when the line bit rate is exactly one eighth of the clock. The bench drives every bit for exactly eight cycles, changes line levels only at falling clock edges, and toggles `enable` only while the line is idle J. The bench sends all 256 byte values, runs of 0xFF that force stuffing, every length from zero to one past the budget, and the two sync-timeout cases.

// File: rtl/usb_ls_rx_deser.sv
module usb_ls_rx_deser #(
  parameter int OSR       = 8,
  parameter int BUF_BYTES = 8,
  parameter int SYNC_WIN  = OSR + OSR / 4,
  localparam int LW = $clog2(BUF_BYTES + 1),
  localparam int PW = $clog2(OSR + OSR / 2),
  localparam int TW = $clog2(SYNC_WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dp_in,
  input  logic          dm_in,
  output logic [7:0]    rx_byte,
  output logic          rx_valid,
  output logic          pkt_end,
  output logic [LW-1:0] pkt_len,
  output logic          overflow,
  output logic          sync_err
);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_WAITJ, S_HUNT, S_CONF, S_RECV} st_t;
  st_t st;

  logic dp_m, dp_s, dm_m, dm_s;
  logic [TW-1:0] tmo;
  logic [PW-1:0] ph;
  logic          prev;
  logic [2:0]    ones, nbit;
  logic [6:0]    sh;
  logic [LW-1:0] left;

  wire is_j    = dm_s & ~dp_s;
  wire is_k    = dp_s & ~dm_s;
  wire is_se0  = ~dp_s & ~dm_s;
  wire dec     = (dm_s == prev);
  wire stuffed = (ones == 3'd6);
  wire tmo_end = (tmo == TW'(SYNC_WIN - 1));
  wire conf_pt = (ph == PW'(OSR + OSR / 2 - 1));
  wire samp    = (st == S_RECV) && (ph == PW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dp_m, dp_s, dm_m, dm_s} <= '0;
    end else begin
      dp_m <= dp_in;
      dp_s <= dp_m;
      dm_m <= dm_in;
      dm_s <= dm_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmo      <= '0;
      ph       <= '0;
      prev     <= 1'b0;
      ones     <= '0;
      nbit     <= '0;
      sh       <= '0;
      left     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      pkt_end  <= 1'b0;
      pkt_len  <= '0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      pkt_end  <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
      if (!enable) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            ones <= '0;
            nbit <= '0;
            if (is_j) st <= S_ARM;
          end
          S_ARM: if (is_k) begin
            st  <= S_WAITJ;
            tmo <= '0;
          end
          S_WAITJ: begin
            if (is_j) begin
              st  <= S_HUNT;
              tmo <= '0;
            end else if (tmo_end) begin
              sync_err <= 1'b1;
              st       <= S_IDLE;
            end else tmo <= tmo + 1'b1;
          end
          S_HUNT: begin
            if (is_k) begin
              st <= S_CONF;
              ph <= '0;
            end else if (tmo_end) begin
              sync_err <= 1'b1;
              st       <= S_IDLE;
            end else tmo <= tmo + 1'b1;
          end
          S_CONF: begin
            if (!conf_pt) ph <= ph + 1'b1;
            else if (is_k) begin
              st   <= S_RECV;
              ph   <= '0;
              prev <= 1'b0;
              ones <= 3'd1;
              nbit <= '0;
              left <= LW'(BUF_BYTES);
            end else begin
              st  <= S_HUNT;
              tmo <= '0;
            end
          end
          S_RECV: begin
            ph <= samp ? '0 : ph + 1'b1;
            if (samp) begin
              prev <= dm_s;
              if (nbit == 3'd1 && is_se0) begin
                pkt_end <= 1'b1;
                pkt_len <= LW'(BUF_BYTES) - left;
                st      <= S_IDLE;
              end else if (stuffed) begin
                ones <= '0;
              end else begin
                ones <= dec ? ones + 1'b1 : 3'd0;
                sh   <= {dec, sh[6:1]};
                nbit <= nbit + 1'b1;
                if (nbit == 3'd7) begin
                  if (left == '0) begin
                    overflow <= 1'b1;
                    st       <= S_IDLE;
                  end else begin
                    rx_byte  <= {dec, sh};
                    rx_valid <= 1'b1;
                    left     <= left - 1'b1;
                  end
                end
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/usb_ls_rx_deser_chk.sv
module usb_ls_rx_deser_chk #(
  parameter int BUF_BYTES = 8,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          rx_valid,
  input logic          pkt_end,
  input logic [LW-1:0] pkt_len,
  input logic          overflow,
  input logic          sync_err
);

  logic [LW:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!enable || pkt_end || overflow || sync_err) seen <= '0;
    else if (rx_valid) seen <= seen + 1'b1;
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, pkt_end, overflow, sync_err}));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_len_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (pkt_len == seen[LW-1:0]) && !seen[LW]);

  assert_budget_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (seen == (LW+1)'(BUF_BYTES)));

  assert_budget_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= (LW+1)'(BUF_BYTES));

  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !(rx_valid || pkt_end || overflow || sync_err));

  assert_sync_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

endmodule

bind usb_ls_rx_deser usb_ls_rx_deser_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
  .pkt_end(pkt_end), .pkt_len(pkt_len), .overflow(overflow), .sync_err(sync_err)
);

// File: tb/test_usb_ls_rx_deser.sv
module test_usb_ls_rx_deser;
  localparam int OSR = 8;
  localparam int BUFB = 8;
  localparam int LW = $clog2(BUFB + 1);

  logic clk = 0, rst_n = 0, enable = 0, dp_in = 0, dm_in = 1;
  logic [7:0] rx_byte;
  logic rx_valid, pkt_end, overflow, sync_err;
  logic [LW-1:0] pkt_len;

  usb_ls_rx_deser #(.OSR(OSR), .BUF_BYTES(BUFB)) i_usb_ls_rx_deser (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dp_in(dp_in), .dm_in(dm_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .pkt_end(pkt_end), .pkt_len(pkt_len),
    .overflow(overflow), .sync_err(sync_err));

  always #5 clk = ~clk;

  int nvec = 0, nbad = 0;
  int ngot = 0, nend = 0, novf = 0, nserr = 0, lastlen = -1;
  logic [7:0] got [0:15];
  logic [7:0] tx [0:15];
  bit finished = 0;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (ngot < 16) got[ngot] = rx_byte;
      ngot++;
    end
    if (pkt_end) begin nend++; lastlen = int'(pkt_len); end
    if (overflow) novf++;
    if (sync_err) nserr++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lv(input bit j, input int nb);
    repeat (nb * OSR) begin @(negedge clk); dp_in = !j; dm_in = j; end
  endtask

  task automatic se0(input int nb);
    repeat (nb * OSR) begin @(negedge clk); dp_in = 0; dm_in = 0; end
  endtask

  task automatic clr();
    ngot = 0; nend = 0; novf = 0; nserr = 0; lastlen = -1;
  endtask

  task automatic send_pkt(input int n);
    bit cur;
    int ones;
    lv(1, 3);
    lv(0, 1); lv(1, 1); lv(0, 1); lv(1, 1);
    lv(0, 1); lv(1, 1); lv(0, 1); lv(0, 1);
    cur = 0; ones = 1;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        if (tx[i][k]) ones++;
        else begin cur = !cur; ones = 0; end
        lv(cur, 1);
        if (ones == 6) begin cur = !cur; ones = 0; lv(cur, 1); end
      end
    se0(2);
    lv(1, 4);
  endtask

  task automatic check_pkt(input int n, input string req);
    int m;
    m = (n > BUFB) ? BUFB : n;
    check(ngot == m, req, ngot, m);
    for (int i = 0; i < m; i++)
      check(got[i] == tx[i], req, int'(got[i]), int'(tx[i]));
    if (n <= BUFB) begin
      check(nend == 1, {req, " R5 end"}, nend, 1);
      check(lastlen == n, {req, " R5 len"}, lastlen, n);
      check(novf == 0, {req, " R6 no ovf"}, novf, 0);
    end else begin
      check(novf == 1, {req, " R6 ovf"}, novf, 1);
      check(nend == 0, {req, " R6 no end"}, nend, 0);
    end
    check(nserr == 0, {req, " R7 no serr"}, nserr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({rx_valid, pkt_end, overflow, sync_err} == 4'b0 && pkt_len == 0, "R1 in reset",
          int'({rx_valid, pkt_end, overflow, sync_err}), 0);
    rst_n = 1;
    @(negedge clk);
    check({rx_valid, pkt_end, overflow, sync_err} == 4'b0 && pkt_len == 0, "R1 after reset",
          int'({rx_valid, pkt_end, overflow, sync_err}), 0);
    enable = 1;
    lv(1, 2);

    // R2 R3 R5: every byte value, eight per packet
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 8; i++) tx[i] = 8'(p * 8 + i);
      clr();
      send_pkt(8);
      check_pkt(8, "R2 R3 sweep");
    end

    // R4 R5: stuffing-heavy runs of every length, zero included
    for (int n = 0; n <= BUFB; n++) begin
      for (int i = 0; i < n; i++) tx[i] = (i % 2 == 0) ? 8'hFF : 8'h7E;
      clr();
      send_pkt(n);
      check_pkt(n, "R4 stuff");
    end

    // R4: five ones after sync forces early stuffing
    tx[0] = 8'h1F; tx[1] = 8'hFC; tx[2] = 8'h3F;
    clr();
    send_pkt(3);
    check_pkt(3, "R4 early stuff");

    // R6: one byte past the budget
    for (int i = 0; i < BUFB + 1; i++) tx[i] = 8'(8'hA5 ^ (i * 37));
    clr();
    send_pkt(BUFB + 1);
    check_pkt(BUFB + 1, "R6 overflow");

    // R7: K that never returns to J
    clr();
    lv(1, 2); lv(0, 5); lv(1, 3);
    check(nserr == 1, "R7 no J", nserr, 1);
    check(ngot == 0 && nend == 0, "R7 no J data", ngot + nend, 0);

    // R7: J that never returns to K
    clr();
    lv(0, 1); lv(1, 5);
    check(nserr == 1, "R7 no K", nserr, 1);
    check(ngot == 0 && nend == 0, "R7 no K data", ngot + nend, 0);

    // R8: disabled receiver ignores a full packet
    for (int i = 0; i < 4; i++) tx[i] = 8'(i + 8'h40);
    enable = 0;
    clr();
    send_pkt(4);
    check(ngot + nend + novf + nserr == 0, "R8 disabled", ngot + nend + novf + nserr, 0);
    enable = 1;
    lv(1, 2);
    clr();
    send_pkt(4);
    check_pkt(4, "R8 re-enabled");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule